// File: doc/BRIEF.md
# Tunnel Control Packet Handler

This block serves the two fixed-format control protocols that reach a PCIe-over-Ethernet tunnel endpoint on its dedicated UDP ports. Upstream logic has already stripped the frame and presents each control request as one 16-bit header word, one 32-bit data word and a flag that selects the protocol. The configuration protocol reads one dword of the endpoint's PCIe configuration space, or writes it under a byte mask, through a simple request/response port. The command protocol reads or writes a small adapter register file. This file holds the local and peer MAC addresses and the local and peer IPv4 addresses used when building tunnel headers. It also has a read-only view of the requester ID that enumeration assigned to the endpoint.

Each accepted request produces exactly one reply. The reply echoes the request's header word and carries either the data that was read or the data that was written. Command requests and unusable configuration requests are answered one cycle after acceptance. Configuration reads and writes hold the block busy until the configuration port responds. The block takes one request at a time and signals this on `req_ready`.

Top module: `tunnel_ctl_handler`

## Requirements
- R1: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the edge that accepts a configuration read or write until the edge at which `cfg_rsp_valid` is sampled high.
- R2: For a configuration request (`req_kind`=0) the header holds the operation in bits 15:14, the byte mask in bits 13:10 and the dword address in bits 9:0. Operation 0 (read) raises `cfg_req_valid` with `cfg_req_we`=0 and `cfg_req_addr` equal to the dword address, starting the cycle after acceptance. The request stays valid and unchanged until `cfg_rsp_valid` is sampled high.
- R3: Configuration operation 1 (write) presents `cfg_req_we`=1, `cfg_req_be` equal to the header mask (bit n enables byte n, bits 8n+7:8n) and `cfg_req_wdata` equal to the request data. Its reply carries the written data.
- R4: The reply to a configuration read appears in the cycle after `cfg_rsp_valid` is sampled, with data equal to `cfg_rsp_rdata` as sampled.
- R5: Configuration operations 2 and 3 make no configuration access. They are answered in the cycle after acceptance with data 32'hFFFFFFFF.
- R6: For a command request (`req_kind`=1) the header holds the opcode in bits 15:8 and the register address in bits 7:0. Opcode 0 (read) returns the register value in the reply one cycle after acceptance. Address 0 is local MAC bits 47:32 in data bits 15:0. Address 1 is local MAC bits 31:0. Addresses 2 and 3 are the same two parts of the peer MAC. Address 4 is the local IP and address 5 is the peer IP. Address 6 is the requester ID.
- R7: Opcode 1 (write) updates the addressed register from the edge of acceptance. A MAC upper write takes data bits 15:0. The reply carries the request data. The register outputs change only through such writes.
- R8: Address 6 reads as {16'h0, `requester_id`}. A write to it leaves every register unchanged and its reply echoes the data.
- R9: An opcode other than 0 or 1, or an address above 6, returns 32'hFFFFFFFF and changes no register.
- R10: After reset the local MAC is 48'h020000000001, the peer MAC is 48'h020000000002, the local IP is 32'hC0A80A01 and the peer IP is 32'hC0A80A02. `rply_valid` and `cfg_req_valid` are low and `req_ready` is high.
- R11: Every accepted request yields exactly one single-cycle `rply_valid` pulse. `rply_hdr` equals the request header and `rply_kind` equals the request kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| req_valid | input | 1 | Request word pair present |
| req_ready | output | 1 | Block can take a request |
| req_kind | input | 1 | 0 configuration protocol, 1 command protocol |
| req_hdr | input | 16 | Request header word |
| req_data | input | 32 | Request data word |
| cfg_req_valid | output | 1 | Configuration access outstanding |
| cfg_req_we | output | 1 | Configuration access is a write |
| cfg_req_be | output | 4 | Byte enables of the write |
| cfg_req_addr | output | 10 | Configuration dword address |
| cfg_req_wdata | output | 32 | Configuration write data |
| cfg_rsp_valid | input | 1 | Configuration access complete |
| cfg_rsp_rdata | input | 32 | Configuration read data |
| requester_id | input | 16 | Requester ID from enumeration |
| local_mac | output | 48 | Local MAC address register |
| peer_mac | output | 48 | Peer MAC address register |
| local_ip | output | 32 | Local IPv4 address register |
| peer_ip | output | 32 | Peer IPv4 address register |
| rply_valid | output | 1 | Reply present for one cycle |
| rply_kind | output | 1 | Protocol of the reply |
| rply_hdr | output | 16 | Echoed header word |
| rply_data | output | 32 | Reply data |

## Verification
A busy state that does not clear shows up as `req_ready` held low, which stalls the next request. A busy state that clears too early shows a reply before `cfg_rsp_valid`, or a second pulse. Either is visible within one cycle of the configuration response. A wrong header hold register shows an echoed header that differs from the request in that same reply. A register file that decodes the wrong address, or takes a write it should ignore, shows on the register output ports the cycle after the write and in the next read-back reply.

// File: rtl/tch_pkg.sv
package tch_pkg;

  localparam int HDR_W      = 16;
  localparam int DATA_W     = 32;
  localparam int CFG_OP_W   = 2;
  localparam int CFG_MASK_W = 4;
  localparam int CFG_ADDR_W = HDR_W - CFG_OP_W - CFG_MASK_W;
  localparam int CMD_OP_W   = 8;
  localparam int CMD_ADDR_W = HDR_W - CMD_OP_W;

  typedef struct packed {
    logic [CFG_OP_W-1:0]   op;
    logic [CFG_MASK_W-1:0] mask;
    logic [CFG_ADDR_W-1:0] addr;
  } cfg_hdr_t;

  typedef struct packed {
    logic [CMD_OP_W-1:0]   op;
    logic [CMD_ADDR_W-1:0] addr;
  } cmd_hdr_t;

  typedef enum logic {
    KIND_CFG = 1'b0,
    KIND_CMD = 1'b1
  } pkt_kind_e;

  typedef enum logic {
    CP_IDLE = 1'b0,
    CP_BUSY = 1'b1
  } cp_state_e;

  localparam logic [CFG_OP_W-1:0] CFG_OP_RD = 2'd0;
  localparam logic [CFG_OP_W-1:0] CFG_OP_WR = 2'd1;
  localparam logic [CMD_OP_W-1:0] CMD_OP_RD = 8'd0;
  localparam logic [CMD_OP_W-1:0] CMD_OP_WR = 8'd1;

  localparam int NUM_MAC = 2;
  localparam int NUM_IP  = 2;
  localparam logic [CMD_ADDR_W-1:0] RA_MAC_BASE = 8'd0;
  localparam logic [CMD_ADDR_W-1:0] RA_IP_BASE  = 8'd4;
  localparam logic [CMD_ADDR_W-1:0] RA_RID      = 8'd6;

endpackage

// File: rtl/tch_decode.sv
module tch_decode
  import tch_pkg::*;
(
  input  logic                  kind,
  input  logic [HDR_W-1:0]      hdr,
  output logic [CFG_MASK_W-1:0] cfg_mask,
  output logic [CFG_ADDR_W-1:0] cfg_addr,
  output logic [CMD_ADDR_W-1:0] cmd_addr,
  output logic                  cfg_rd,
  output logic                  cfg_wr,
  output logic                  cfg_bad,
  output logic                  cmd_rd,
  output logic                  cmd_wr,
  output logic                  cmd_bad
);

  cfg_hdr_t ch;
  cmd_hdr_t mh;
  logic     is_cfg;

  assign ch       = cfg_hdr_t'(hdr);
  assign mh       = cmd_hdr_t'(hdr);
  assign is_cfg   = (kind == KIND_CFG);
  assign cfg_mask = ch.mask;
  assign cfg_addr = ch.addr;
  assign cmd_addr = mh.addr;

  always_comb begin
    cfg_rd  = 1'b0;
    cfg_wr  = 1'b0;
    cfg_bad = 1'b0;
    cmd_rd  = 1'b0;
    cmd_wr  = 1'b0;
    cmd_bad = 1'b0;
    if (is_cfg) begin
      if (ch.op == CFG_OP_RD)      cfg_rd  = 1'b1;
      else if (ch.op == CFG_OP_WR) cfg_wr  = 1'b1;
      else                         cfg_bad = 1'b1;
    end else begin
      if (mh.op == CMD_OP_RD)      cmd_rd  = 1'b1;
      else if (mh.op == CMD_OP_WR) cmd_wr  = 1'b1;
      else                         cmd_bad = 1'b1;
    end
  end

endmodule

// File: rtl/tch_adapter_regs.sv
module tch_adapter_regs
  import tch_pkg::*;
#(
  parameter int               MAC_W     = 48,
  parameter int               IP_W      = 32,
  parameter int               RID_W     = 16,
  parameter logic [MAC_W-1:0] LMAC_RST  = 48'h0200_0000_0001,
  parameter logic [MAC_W-1:0] PMAC_RST  = 48'h0200_0000_0002,
  parameter logic [IP_W-1:0]  LIP_RST   = 32'hC0A8_0A01,
  parameter logic [IP_W-1:0]  PIP_RST   = 32'hC0A8_0A02
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [CMD_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [RID_W-1:0]      requester_id,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  addr_known,
  output logic [MAC_W-1:0]      local_mac,
  output logic [MAC_W-1:0]      peer_mac,
  output logic [IP_W-1:0]       local_ip,
  output logic [IP_W-1:0]       peer_ip
);

  localparam int MAC_HI_W = MAC_W - DATA_W;

  logic [MAC_W-1:0] mac_all [NUM_MAC];
  logic [IP_W-1:0]  ip_all  [NUM_IP];

  for (genvar m = 0; m < NUM_MAC; m++) begin : g_mac
    localparam logic [MAC_W-1:0] RST_V = (m == 0) ? LMAC_RST : PMAC_RST;
    localparam logic [CMD_ADDR_W-1:0] A_HI = RA_MAC_BASE + CMD_ADDR_W'(2 * m);
    localparam logic [CMD_ADDR_W-1:0] A_LO = RA_MAC_BASE + CMD_ADDR_W'(2 * m + 1);
    logic [MAC_W-1:0] q;
    logic [MAC_W-1:0] d;
    logic             ce;

    always_comb begin
      d  = q;
      ce = 1'b0;
      if (wr_en && (addr == A_HI)) begin
        d[MAC_W-1:DATA_W] = wr_data[MAC_HI_W-1:0];
        ce                = 1'b1;
      end else if (wr_en && (addr == A_LO)) begin
        d[DATA_W-1:0] = wr_data;
        ce            = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST_V;
      else if (ce) q <= d;
    end

    assign mac_all[m] = q;
  end

  for (genvar i = 0; i < NUM_IP; i++) begin : g_ip
    localparam logic [IP_W-1:0] RST_V = (i == 0) ? LIP_RST : PIP_RST;
    localparam logic [CMD_ADDR_W-1:0] A_IP = RA_IP_BASE + CMD_ADDR_W'(i);
    logic [IP_W-1:0] q;
    logic [IP_W-1:0] d;
    logic            ce;

    always_comb begin
      ce = wr_en && (addr == A_IP);
      d  = ce ? wr_data[IP_W-1:0] : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST_V;
      else if (ce) q <= d;
    end

    assign ip_all[i] = q;
  end

  always_comb begin
    rd_data    = '1;
    addr_known = 1'b1;
    case (addr)
      RA_MAC_BASE:        rd_data = DATA_W'(mac_all[0][MAC_W-1:DATA_W]);
      RA_MAC_BASE + 8'd1: rd_data = mac_all[0][DATA_W-1:0];
      RA_MAC_BASE + 8'd2: rd_data = DATA_W'(mac_all[1][MAC_W-1:DATA_W]);
      RA_MAC_BASE + 8'd3: rd_data = mac_all[1][DATA_W-1:0];
      RA_IP_BASE:         rd_data = DATA_W'(ip_all[0]);
      RA_IP_BASE + 8'd1:  rd_data = DATA_W'(ip_all[1]);
      RA_RID:             rd_data = DATA_W'(requester_id);
      default:            addr_known = 1'b0;
    endcase
  end

  assign local_mac = mac_all[0];
  assign peer_mac  = mac_all[1];
  assign local_ip  = ip_all[0];
  assign peer_ip   = ip_all[1];

  // R7: without a write on the previous edge the register outputs hold
  a_r7_regs_hold_without_write: assert property (
    @(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable({local_mac, peer_mac, local_ip, peer_ip})
  );

  // R9: a write to an unmapped address leaves all registers untouched
  a_r9_unknown_write_no_effect: assert property (
    @(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_known) |=> $stable({local_mac, peer_mac, local_ip, peer_ip})
  );

endmodule

// File: rtl/tch_cfg_port.sv
module tch_cfg_port
  import tch_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  start_we,
  input  logic [CFG_MASK_W-1:0] start_be,
  input  logic [CFG_ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0]     start_wdata,
  output logic                  cfg_req_valid,
  output logic                  cfg_req_we,
  output logic [CFG_MASK_W-1:0] cfg_req_be,
  output logic [CFG_ADDR_W-1:0] cfg_req_addr,
  output logic [DATA_W-1:0]     cfg_req_wdata,
  input  logic                  cfg_rsp_valid,
  input  logic [DATA_W-1:0]     cfg_rsp_rdata,
  output logic                  busy,
  output logic                  done,
  output logic [DATA_W-1:0]     done_data
);

  cp_state_e             state_q, state_d;
  logic                  ld;
  logic                  we_q;
  logic [CFG_MASK_W-1:0] be_q;
  logic [CFG_ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0]     wdata_q;

  always_comb begin
    state_d = state_q;
    ld      = 1'b0;
    if (state_q == CP_IDLE) begin
      if (start) begin
        state_d = CP_BUSY;
        ld      = 1'b1;
      end
    end else if (cfg_rsp_valid) begin
      state_d = CP_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CP_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      be_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (ld) begin
      we_q    <= start_we;
      be_q    <= start_we ? start_be : '0;
      addr_q  <= start_addr;
      wdata_q <= start_wdata;
    end
  end

  assign busy          = (state_q == CP_BUSY);
  assign cfg_req_valid = busy;
  assign cfg_req_we    = we_q;
  assign cfg_req_be    = be_q;
  assign cfg_req_addr  = addr_q;
  assign cfg_req_wdata = wdata_q;
  assign done          = busy && cfg_rsp_valid;
  assign done_data     = we_q ? wdata_q : cfg_rsp_rdata;

  // R2: an outstanding access keeps its fields until answered
  a_r2_request_held: assert property (
    @(posedge clk) disable iff (!rst_n)
    (cfg_req_valid && !cfg_rsp_valid) |=>
      (cfg_req_valid && $stable(cfg_req_addr) && $stable(cfg_req_we) &&
       $stable(cfg_req_be) && $stable(cfg_req_wdata))
  );

  // R1: the access ends on the edge that sees the response
  a_r1_ends_on_response: assert property (
    @(posedge clk) disable iff (!rst_n)
    (cfg_req_valid && cfg_rsp_valid) |=> !cfg_req_valid
  );

endmodule

// File: rtl/tch_reply_build.sv
module tch_reply_build
  import tch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              kind,
  input  logic [HDR_W-1:0]  hdr,
  input  logic              imm_valid,
  input  logic [DATA_W-1:0] imm_data,
  input  logic              cfg_done,
  input  logic [DATA_W-1:0] cfg_data,
  output logic              rply_valid,
  output logic              rply_kind,
  output logic [HDR_W-1:0]  rply_hdr,
  output logic [DATA_W-1:0] rply_data
);

  logic              hold_kind_q;
  logic [HDR_W-1:0]  hold_hdr_q;
  logic              v_d, k_d;
  logic [HDR_W-1:0]  h_d;
  logic [DATA_W-1:0] d_d;
  logic              out_ce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_kind_q <= 1'b0;
      hold_hdr_q  <= '0;
    end else if (accept) begin
      hold_kind_q <= kind;
      hold_hdr_q  <= hdr;
    end
  end

  always_comb begin
    v_d    = 1'b0;
    k_d    = rply_kind;
    h_d    = rply_hdr;
    d_d    = rply_data;
    out_ce = 1'b0;
    if (imm_valid) begin
      v_d    = 1'b1;
      k_d    = kind;
      h_d    = hdr;
      d_d    = imm_data;
      out_ce = 1'b1;
    end else if (cfg_done) begin
      v_d    = 1'b1;
      k_d    = hold_kind_q;
      h_d    = hold_hdr_q;
      d_d    = cfg_data;
      out_ce = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rply_valid <= 1'b0;
    else        rply_valid <= v_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rply_kind <= 1'b0;
      rply_hdr  <= '0;
      rply_data <= '0;
    end else if (out_ce) begin
      rply_kind <= k_d;
      rply_hdr  <= h_d;
      rply_data <= d_d;
    end
  end

  // R11: the two reply sources never compete in one cycle
  a_r11_sources_exclusive: assert property (
    @(posedge clk) disable iff (!rst_n)
    !(imm_valid && cfg_done)
  );

endmodule

// File: rtl/tunnel_ctl_handler.sv
module tunnel_ctl_handler
  import tch_pkg::*;
#(
  parameter int               MAC_W    = 48,
  parameter int               IP_W     = 32,
  parameter int               RID_W    = 16,
  parameter int               SYNC_LEN = 2,
  parameter logic [MAC_W-1:0] LMAC_RST = 48'h0200_0000_0001,
  parameter logic [MAC_W-1:0] PMAC_RST = 48'h0200_0000_0002,
  parameter logic [IP_W-1:0]  LIP_RST  = 32'hC0A8_0A01,
  parameter logic [IP_W-1:0]  PIP_RST  = 32'hC0A8_0A02
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_kind,
  input  logic [HDR_W-1:0]      req_hdr,
  input  logic [DATA_W-1:0]     req_data,
  output logic                  cfg_req_valid,
  output logic                  cfg_req_we,
  output logic [CFG_MASK_W-1:0] cfg_req_be,
  output logic [CFG_ADDR_W-1:0] cfg_req_addr,
  output logic [DATA_W-1:0]     cfg_req_wdata,
  input  logic                  cfg_rsp_valid,
  input  logic [DATA_W-1:0]     cfg_rsp_rdata,
  input  logic [RID_W-1:0]      requester_id,
  output logic [MAC_W-1:0]      local_mac,
  output logic [MAC_W-1:0]      peer_mac,
  output logic [IP_W-1:0]       local_ip,
  output logic [IP_W-1:0]       peer_ip,
  output logic                  rply_valid,
  output logic                  rply_kind,
  output logic [HDR_W-1:0]      rply_hdr,
  output logic [DATA_W-1:0]     rply_data
);

  logic [SYNC_LEN-1:0] rst_sync_q;
  logic                core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_LEN-2:0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[SYNC_LEN-1];

  logic [CFG_MASK_W-1:0] d_mask;
  logic [CFG_ADDR_W-1:0] d_cfg_addr;
  logic [CMD_ADDR_W-1:0] d_cmd_addr;
  logic d_cfg_rd, d_cfg_wr, d_cfg_bad, d_cmd_rd, d_cmd_wr, d_cmd_bad;

  tch_decode u_decode (
    .kind     (req_kind),
    .hdr      (req_hdr),
    .cfg_mask (d_mask),
    .cfg_addr (d_cfg_addr),
    .cmd_addr (d_cmd_addr),
    .cfg_rd   (d_cfg_rd),
    .cfg_wr   (d_cfg_wr),
    .cfg_bad  (d_cfg_bad),
    .cmd_rd   (d_cmd_rd),
    .cmd_wr   (d_cmd_wr),
    .cmd_bad  (d_cmd_bad)
  );

  logic              busy;
  logic              accept;
  logic              cfg_start;
  logic              imm_valid;
  logic [DATA_W-1:0] imm_data;
  logic [DATA_W-1:0] reg_rd_data;
  logic              reg_known;
  logic              cfg_done;
  logic [DATA_W-1:0] cfg_done_data;

  assign req_ready = core_rst_n && !busy;
  assign accept    = req_valid && req_ready;
  assign cfg_start = accept && (d_cfg_rd || d_cfg_wr);
  assign imm_valid = accept && !(d_cfg_rd || d_cfg_wr);

  tch_adapter_regs #(
    .MAC_W    (MAC_W),
    .IP_W     (IP_W),
    .RID_W    (RID_W),
    .LMAC_RST (LMAC_RST),
    .PMAC_RST (PMAC_RST),
    .LIP_RST  (LIP_RST),
    .PIP_RST  (PIP_RST)
  ) u_regs (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .wr_en        (accept && d_cmd_wr),
    .addr         (d_cmd_addr),
    .wr_data      (req_data),
    .requester_id (requester_id),
    .rd_data      (reg_rd_data),
    .addr_known   (reg_known),
    .local_mac    (local_mac),
    .peer_mac     (peer_mac),
    .local_ip     (local_ip),
    .peer_ip      (peer_ip)
  );

  always_comb begin
    imm_data = '1;
    if (d_cmd_rd && reg_known)      imm_data = reg_rd_data;
    else if (d_cmd_wr && reg_known) imm_data = req_data;
  end

  tch_cfg_port u_cfg (
    .clk           (clk),
    .rst_n         (core_rst_n),
    .start         (cfg_start),
    .start_we      (d_cfg_wr),
    .start_be      (d_mask),
    .start_addr    (d_cfg_addr),
    .start_wdata   (req_data),
    .cfg_req_valid (cfg_req_valid),
    .cfg_req_we    (cfg_req_we),
    .cfg_req_be    (cfg_req_be),
    .cfg_req_addr  (cfg_req_addr),
    .cfg_req_wdata (cfg_req_wdata),
    .cfg_rsp_valid (cfg_rsp_valid),
    .cfg_rsp_rdata (cfg_rsp_rdata),
    .busy          (busy),
    .done          (cfg_done),
    .done_data     (cfg_done_data)
  );

  tch_reply_build u_reply (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .accept     (accept),
    .kind       (req_kind),
    .hdr        (req_hdr),
    .imm_valid  (imm_valid),
    .imm_data   (imm_data),
    .cfg_done   (cfg_done),
    .cfg_data   (cfg_done_data),
    .rply_valid (rply_valid),
    .rply_kind  (rply_kind),
    .rply_hdr   (rply_hdr),
    .rply_data  (rply_data)
  );

  // R1: no new request is taken while a configuration access is open
  a_r1_busy_blocks_ready: assert property (
    @(posedge clk) disable iff (!core_rst_n)
    cfg_req_valid |-> !req_ready
  );

  // R5 / R6: immediately answered requests reply on the next cycle
  a_r6_immediate_reply: assert property (
    @(posedge clk) disable iff (!core_rst_n)
    (accept && !cfg_start) |=> (rply_valid && rply_kind == $past(req_kind))
  );

  // R4: a completed configuration access yields a configuration reply
  a_r4_cfg_reply_follows: assert property (
    @(posedge clk) disable iff (!core_rst_n)
    (cfg_req_valid && cfg_rsp_valid) |=> (rply_valid && rply_kind == KIND_CFG)
  );

  // R5: unusable configuration operations never reach the port
  a_r5_bad_op_no_access: assert property (
    @(posedge clk) disable iff (!core_rst_n)
    (accept && d_cfg_bad) |=> !cfg_req_valid
  );

  // R11: a reply never appears without a request or response behind it
  a_r11_reply_has_cause: assert property (
    @(posedge clk) disable iff (!core_rst_n)
    !(accept || (cfg_req_valid && cfg_rsp_valid)) |=> !rply_valid
  );

endmodule

// File: tb/tunnel_ctl_handler_bench.sv
module tunnel_ctl_handler_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_kind;
  logic [15:0] req_hdr;
  logic [31:0] req_data;
  logic        cfg_req_valid, cfg_req_we;
  logic [3:0]  cfg_req_be;
  logic [9:0]  cfg_req_addr;
  logic [31:0] cfg_req_wdata;
  logic        cfg_rsp_valid;
  logic [31:0] cfg_rsp_rdata;
  logic [15:0] requester_id;
  logic [47:0] local_mac, peer_mac;
  logic [31:0] local_ip, peer_ip;
  logic        rply_valid, rply_kind;
  logic [15:0] rply_hdr;
  logic [31:0] rply_data;

  int checks = 0;
  int fails  = 0;

  logic [31:0] cfg_mem [1024];
  logic [47:0] s_lmac, s_pmac;
  logic [31:0] s_lip, s_pip;

  always #5 clk = ~clk;

  tunnel_ctl_handler u_tunnel_ctl_handler (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_kind (req_kind),
    .req_hdr (req_hdr), .req_data (req_data),
    .cfg_req_valid (cfg_req_valid), .cfg_req_we (cfg_req_we),
    .cfg_req_be (cfg_req_be), .cfg_req_addr (cfg_req_addr),
    .cfg_req_wdata (cfg_req_wdata),
    .cfg_rsp_valid (cfg_rsp_valid), .cfg_rsp_rdata (cfg_rsp_rdata),
    .requester_id (requester_id),
    .local_mac (local_mac), .peer_mac (peer_mac),
    .local_ip (local_ip), .peer_ip (peer_ip),
    .rply_valid (rply_valid), .rply_kind (rply_kind),
    .rply_hdr (rply_hdr), .rply_data (rply_data)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] mk_cfg(input logic [1:0] op, input logic [3:0] m,
                                         input logic [9:0] a);
    return {op, m, a};
  endfunction

  function automatic logic [15:0] mk_cmd(input logic [7:0] op, input logic [7:0] a);
    return {op, a};
  endfunction

  function automatic logic [31:0] cmd_read(input logic [7:0] a);
    case (a)
      8'd0:    return {16'h0, s_lmac[47:32]};
      8'd1:    return s_lmac[31:0];
      8'd2:    return {16'h0, s_pmac[47:32]};
      8'd3:    return s_pmac[31:0];
      8'd4:    return s_lip;
      8'd5:    return s_pip;
      8'd6:    return {16'h0, requester_id};
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic cmd_write_model(input logic [7:0] a, input logic [31:0] d);
    case (a)
      8'd0: s_lmac[47:32] = d[15:0];
      8'd1: s_lmac[31:0]  = d;
      8'd2: s_pmac[47:32] = d[15:0];
      8'd3: s_pmac[31:0]  = d;
      8'd4: s_lip         = d;
      8'd5: s_pip         = d;
      default: ;
    endcase
  endtask

  task automatic do_req(input logic kind, input logic [15:0] hdr,
                        input logic [31:0] data, input int dly);
    logic [1:0]  cop   = hdr[15:14];
    logic [3:0]  cmask = hdr[13:10];
    logic [9:0]  caddr = hdr[9:0];
    logic [7:0]  mop   = hdr[15:8];
    logic [7:0]  maddr = hdr[7:0];
    logic [31:0] exp_d;
    string       tg;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_hdr = hdr; req_data = data;
    @(negedge clk);
    req_valid = 1'b0;
    req_hdr   = $urandom;
    req_data  = $urandom;
    if (kind == 1'b0 && cop < 2'd2) begin
      chk("R1 ready low while busy", {63'b0, req_ready}, 64'd0);
      chk("R2 access raised", {63'b0, cfg_req_valid}, 64'd1);
      chk("R2 dword address", {54'b0, cfg_req_addr}, {54'b0, caddr});
      chk("R3 write flag", {63'b0, cfg_req_we}, {63'b0, (cop == 2'd1)});
      if (cop == 2'd1) begin
        chk("R3 byte enables", {60'b0, cfg_req_be}, {60'b0, cmask});
        chk("R3 write data", {32'b0, cfg_req_wdata}, {32'b0, data});
      end
      for (int i = 0; i < dly; i++) begin
        @(negedge clk);
        chk("R2 held valid", {63'b0, cfg_req_valid}, 64'd1);
        chk("R2 held address", {54'b0, cfg_req_addr}, {54'b0, caddr});
        chk("R11 no early reply", {63'b0, rply_valid}, 64'd0);
      end
      cfg_rsp_valid = 1'b1;
      cfg_rsp_rdata = cfg_mem[caddr];
      if (cop == 2'd1) begin
        exp_d = data;
        for (int b = 0; b < 4; b++)
          if (cmask[b]) cfg_mem[caddr][b*8 +: 8] = data[b*8 +: 8];
        tg = "R3 write reply data";
      end else begin
        exp_d = cfg_mem[caddr];
        tg = "R4 read reply data";
      end
      @(negedge clk);
      cfg_rsp_valid = 1'b0;
      cfg_rsp_rdata = $urandom;
      chk(tg, {32'b0, rply_data}, {32'b0, exp_d});
    end else if (kind == 1'b0) begin
      chk("R5 no access", {63'b0, cfg_req_valid}, 64'd0);
      chk("R5 all-ones data", {32'b0, rply_data}, 64'hFFFF_FFFF);
    end else begin
      if (mop == 8'd0) begin
        exp_d = cmd_read(maddr);
        tg = (maddr == 8'd6) ? "R8 requester id read" :
             (maddr > 8'd6)  ? "R9 unknown address read" : "R6 register read";
      end else if (mop == 8'd1) begin
        exp_d = (maddr <= 8'd6) ? data : 32'hFFFF_FFFF;
        cmd_write_model(maddr, data);
        tg = (maddr == 8'd6) ? "R8 read-only write echo" :
             (maddr > 8'd6)  ? "R9 unknown address write" : "R7 write reply";
      end else begin
        exp_d = 32'hFFFF_FFFF;
        tg = "R9 unknown opcode";
      end
      chk("R1 ready stays high", {63'b0, req_ready}, 64'd1);
      chk(tg, {32'b0, rply_data}, {32'b0, exp_d});
    end
    chk("R11 reply valid", {63'b0, rply_valid}, 64'd1);
    chk("R11 reply header", {48'b0, rply_hdr}, {48'b0, hdr});
    chk("R11 reply kind", {63'b0, rply_kind}, {63'b0, kind});
    @(negedge clk);
    chk("R11 single reply", {63'b0, rply_valid}, 64'd0);
    chk("R7 local mac", {16'b0, local_mac}, {16'b0, s_lmac});
    chk("R7 peer mac", {16'b0, peer_mac}, {16'b0, s_pmac});
    chk("R7 local ip", {32'b0, local_ip}, {32'b0, s_lip});
    chk("R7 peer ip", {32'b0, peer_ip}, {32'b0, s_pip});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int a = 0; a < 1024; a++) cfg_mem[a] = 32'h5A00_0000 ^ (a * 32'h0001_0003);
    s_lmac = 48'h0200_0000_0001; s_pmac = 48'h0200_0000_0002;
    s_lip  = 32'hC0A8_0A01;      s_pip  = 32'hC0A8_0A02;
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 1'b0; req_hdr = '0; req_data = '0;
    cfg_rsp_valid = 1'b0; cfg_rsp_rdata = '0; requester_id = 16'hBEEF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 reply idle", {63'b0, rply_valid}, 64'd0);
    chk("R10 no access", {63'b0, cfg_req_valid}, 64'd0);
    chk("R10 ready", {63'b0, req_ready}, 64'd1);
    chk("R10 local mac", {16'b0, local_mac}, {16'b0, 48'h0200_0000_0001});
    chk("R10 peer mac", {16'b0, peer_mac}, {16'b0, 48'h0200_0000_0002});
    chk("R10 local ip", {32'b0, local_ip}, 64'hC0A8_0A01);
    chk("R10 peer ip", {32'b0, peer_ip}, 64'hC0A8_0A02);

    // directed corners
    do_req(1'b0, mk_cfg(2'd0, 4'h0, 10'd0), 32'h0, 0);
    do_req(1'b0, mk_cfg(2'd0, 4'hF, 10'd1023), 32'h0, 3);
    do_req(1'b0, mk_cfg(2'd1, 4'b0101, 10'd5), 32'hA1B2_C3D4, 1);
    do_req(1'b0, mk_cfg(2'd0, 4'h0, 10'd5), 32'h0, 0);
    do_req(1'b0, mk_cfg(2'd1, 4'h0, 10'd6), 32'h1111_2222, 2);
    do_req(1'b0, mk_cfg(2'd0, 4'h0, 10'd6), 32'h0, 0);
    do_req(1'b0, mk_cfg(2'd2, 4'hF, 10'd7), 32'h0, 0);
    do_req(1'b0, mk_cfg(2'd3, 4'hF, 10'd8), 32'h0, 0);
    for (int a = 0; a < 7; a++) do_req(1'b1, mk_cmd(8'd0, 8'(a)), 32'h0, 0);
    do_req(1'b1, mk_cmd(8'd1, 8'd0), 32'hFFFF_1234, 0);
    do_req(1'b1, mk_cmd(8'd0, 8'd0), 32'h0, 0);
    do_req(1'b1, mk_cmd(8'd1, 8'd6), 32'h0000_5555, 0);
    do_req(1'b1, mk_cmd(8'd0, 8'd6), 32'h0, 0);
    requester_id = 16'h0102;
    do_req(1'b1, mk_cmd(8'd0, 8'd6), 32'h0, 0);
    do_req(1'b1, mk_cmd(8'd2, 8'd4), 32'hDEAD_BEEF, 0);
    do_req(1'b1, mk_cmd(8'hFF, 8'd1), 32'hDEAD_BEEF, 0);
    do_req(1'b1, mk_cmd(8'd1, 8'd7), 32'hDEAD_BEEF, 0);
    do_req(1'b1, mk_cmd(8'd0, 8'hFF), 32'h0, 0);
    do_req(1'b1, mk_cmd(8'd1, 8'hFF), 32'h0BAD_F00D, 0);

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r = $urandom;
      if (r[0]) begin
        logic [1:0] op;
        case (r[3:1])
          3'd0, 3'd1, 3'd2, 3'd3: op = 2'd0;
          3'd4, 3'd5, 3'd6:       op = 2'd1;
          default:                op = r[4] ? 2'd3 : 2'd2;
        endcase
        do_req(1'b0, mk_cfg(op, 4'($urandom), 10'($urandom)), $urandom, int'($urandom % 4));
      end else begin
        logic [7:0] op = (r[3:1] == 3'd7) ? 8'($urandom) : {7'b0, r[2]};
        logic [7:0] ad = (r[6:4] == 3'd7) ? 8'($urandom) : 8'($urandom % 9);
        do_req(1'b1, mk_cmd(op, ad), $urandom, 0);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule